// File: doc/BRIEF.md
# Clos Middle Switch Selector

This block chooses the intermediary (middle-stage) switch for a new connection through a three-stage Clos network. A requester presents the index of the input switch and of the output switch, together with two occupancy vectors: one says which of the input switch's links toward the middle stage are taken, the other says the same for the output switch. A bit set in either vector rules out that middle switch. Among the middle switches left over, the lowest-numbered one is tried first.

The information in the vectors may be stale. For that reason the block keeps its own relay table: for every middle switch, which input-side and output-side links are really in use. A tentative choice is checked against that table. If the check finds a conflict, that switch is excluded for the rest of the request and the next free one is tried. Once more than a fixed number of such cancellations have occurred, the block stops and asks the requester for a fresh vector instead.

When no middle switch remains, the result is "blocked", and the requester waits before trying again. A committed connection marks its links in the relay table. A separate release port frees them when the circuit is torn down.

Top module: `clos_mid_selector`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0, and the relay table holds no busy link, so a first request with all-zero vectors is granted middle switch 0.
- R2: Bit k of `req_in_vec` and of `req_out_vec` stands for middle switch k, and a 1 means that link is occupied. The candidate set is the zero bits of (`req_in_vec` OR `req_out_vec`), and the lowest-numbered candidate not yet cancelled for this request is the one tried.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Without cancellations, `res_valid` is high during the second cycle after acceptance. A grant reports `res_code` = 1 and the switch number in `res_mid`. In that case `res_in_vec` and `res_out_vec` equal the request vectors with bit `res_mid` set.
- R4: A grant marks, in the relay table, the link from the request's input switch to the chosen middle switch and the link from that middle switch to the request's output switch as busy.
- R5: A candidate is cancelled when the relay table shows either of its two needed links busy. That switch is then excluded and the next candidate is tried, and each cancellation adds one cycle of latency.
- R6: When the cancellation count for one request would exceed CANCEL_LIMIT (default 3), the request ends with `res_code` = 3 (resend) on that same cycle, and the relay table is left unchanged.
- R7: When the candidate set is empty, the request ends with `res_code` = 2 (blocked) and the relay table is left unchanged.
- R8: A pulse on `rel_valid` clears the relay-table links given by `rel_mid`, `rel_in_sw` and `rel_out_sw`, which makes that middle switch usable again for those switches.
- R9: Each accepted request yields exactly one one-cycle `res_valid` pulse. `req_ready` is 0 from acceptance until that pulse, and `req_valid` has no effect in those cycles.
- R10: When every candidate is cancelled before the limit is reached, the request ends blocked (`res_code` = 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Connection request strobe |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_in_sw | input | $clog2(N_IN) | Input switch index |
| req_out_sw | input | $clog2(N_OUT) | Output switch index |
| req_in_vec | input | N_MID | Input switch occupancy toward middle stage |
| req_out_vec | input | N_MID | Output switch occupancy from middle stage |
| rel_valid | input | 1 | Release strobe |
| rel_mid | input | $clog2(N_MID) | Middle switch of the circuit to free |
| rel_in_sw | input | $clog2(N_IN) | Input switch of the circuit to free |
| rel_out_sw | input | $clog2(N_OUT) | Output switch of the circuit to free |
| res_valid | output | 1 | Result strobe, one cycle |
| res_code | output | 2 | 1 grant, 2 blocked, 3 resend |
| res_mid | output | $clog2(N_MID) | Granted middle switch |
| res_in_vec | output | N_MID | Input vector with the grant bit set |
| res_out_vec | output | N_MID | Output vector with the grant bit set |

## Verification
Several properties are checked by assertions on every cycle. The switch being tried is never excluded by the latched vectors or by the cancel mask. A commit only lands on relay-table links that are free. A release leaves its links clear. The cancel counter stays within its limit, and results come as single pulses while the block is idle. Other behaviour can only be shown by the bench's scenarios: which switch is chosen for a given vector pair, the latency added by each cancellation, the point at which a resend replaces a retry, a blocked result after exhausted candidates, and a freed switch being granted again.

// File: rtl/clos_sel_pkg.sv
package clos_sel_pkg;

   typedef enum logic [1:0] {
      RES_NONE    = 2'd0,
      RES_GRANT   = 2'd1,
      RES_BLOCKED = 2'd2,
      RES_RESEND  = 2'd3
   } res_code_e;

   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_SEARCH = 1'b1
   } sel_state_e;

endpackage

// File: rtl/clos_free_pick.sv
// Lowest-index set bit of a free vector.
module clos_free_pick #(
   parameter int N     = 32,
   localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    free_vec,
   output logic            found,
   output logic [IDXW-1:0] idx
);

   initial begin
      if (N < 2) $fatal(1, "clos_free_pick: N must be at least 2");
   end

   always_comb begin
      found = |free_vec;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (free_vec[i]) idx = IDXW'(i);
      end
   end

endmodule

// File: rtl/clos_relay_table.sv
// Per-middle-switch record of busy input-side and output-side links.
module clos_relay_table #(
   parameter int N_MID  = 32,
   parameter int N_IN   = 8,
   parameter int N_OUT  = 8,
   localparam int MIDW  = (N_MID > 1) ? $clog2(N_MID) : 1,
   localparam int INW   = (N_IN  > 1) ? $clog2(N_IN)  : 1,
   localparam int OUTW  = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [MIDW-1:0] look_mid,
   input  logic [INW-1:0]  look_in,
   input  logic [OUTW-1:0] look_out,
   output logic            look_busy,
   input  logic            cmt_en,
   input  logic [MIDW-1:0] cmt_mid,
   input  logic [INW-1:0]  cmt_in,
   input  logic [OUTW-1:0] cmt_out,
   input  logic            rel_en,
   input  logic [MIDW-1:0] rel_mid,
   input  logic [INW-1:0]  rel_in,
   input  logic [OUTW-1:0] rel_out
);

   initial begin
      if (N_IN < 2 || N_OUT < 2) $fatal(1, "clos_relay_table: need at least two outer switches");
      if (N_MID * (N_IN + N_OUT) > 4096) $fatal(1, "clos_relay_table: table too large");
   end

   logic [N_IN-1:0]  in_busy  [N_MID];
   logic [N_OUT-1:0] out_busy [N_MID];

   for (genvar m = 0; m < N_MID; m++) begin : g_mid
      logic hit_cmt, hit_rel;
      assign hit_cmt = cmt_en && (cmt_mid == MIDW'(m));
      assign hit_rel = rel_en && (rel_mid == MIDW'(m));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_busy[m]  <= '0;
            out_busy[m] <= '0;
         end else if (hit_cmt || hit_rel) begin
            in_busy[m]  <= (in_busy[m]
                            & ~(hit_rel ? (N_IN'(1) << rel_in) : '0))
                            | (hit_cmt ? (N_IN'(1) << cmt_in) : '0);
            out_busy[m] <= (out_busy[m]
                            & ~(hit_rel ? (N_OUT'(1) << rel_out) : '0))
                            | (hit_cmt ? (N_OUT'(1) << cmt_out) : '0);
         end
      end
   end

   assign look_busy = in_busy[look_mid][look_in] | out_busy[look_mid][look_out];

   // R4: a commit only lands on links the table shows as free
   a_r4_commit_free: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_en |-> (!in_busy[cmt_mid][cmt_in] && !out_busy[cmt_mid][cmt_out]));

   // R4: the committed links read back busy on the next cycle
   a_r4_commit_marks: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_en |=> (in_busy[$past(cmt_mid)][$past(cmt_in)]
                  && out_busy[$past(cmt_mid)][$past(cmt_out)]));

   // R8: a release without a concurrent commit leaves its links clear
   a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_en && !cmt_en) |=> (!in_busy[$past(rel_mid)][$past(rel_in)]
                               && !out_busy[$past(rel_mid)][$past(rel_out)]));

endmodule

// File: rtl/clos_sel_ctrl.sv
// Request sequencing: latch vectors, try candidates, count cancels, report.
module clos_sel_ctrl
   import clos_sel_pkg::*;
#(
   parameter int N_MID        = 32,
   parameter int N_IN         = 8,
   parameter int N_OUT        = 8,
   parameter int CANCEL_LIMIT = 3,
   localparam int MIDW  = (N_MID > 1) ? $clog2(N_MID) : 1,
   localparam int INW   = (N_IN  > 1) ? $clog2(N_IN)  : 1,
   localparam int OUTW  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
   localparam int CNTW  = $clog2(CANCEL_LIMIT + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [INW-1:0]   req_in_sw,
   input  logic [OUTW-1:0]  req_out_sw,
   input  logic [N_MID-1:0] req_in_vec,
   input  logic [N_MID-1:0] req_out_vec,
   output logic [N_MID-1:0] free_vec,
   input  logic             pick_found,
   input  logic [MIDW-1:0]  pick_idx,
   output logic [INW-1:0]   cur_in_sw,
   output logic [OUTW-1:0]  cur_out_sw,
   input  logic             pick_busy,
   output logic             cmt_en,
   output logic             res_valid,
   output logic [1:0]       res_code,
   output logic [MIDW-1:0]  res_mid,
   output logic [N_MID-1:0] res_in_vec,
   output logic [N_MID-1:0] res_out_vec
);

   initial begin
      if (CANCEL_LIMIT < 1) $fatal(1, "clos_sel_ctrl: CANCEL_LIMIT must be positive");
   end

   localparam logic [CNTW-1:0] LIM = CNTW'(CANCEL_LIMIT);

   sel_state_e       state_q;
   logic [N_MID-1:0] in_v_q, out_v_q, mask_q;
   logic [INW-1:0]   in_sw_q;
   logic [OUTW-1:0]  out_sw_q;
   logic [CNTW-1:0]  cnt_q;
   logic             accept, searching, do_block, do_cancel, do_resend;
   logic [N_MID-1:0] pick_onehot;

   assign req_ready   = (state_q == ST_IDLE);
   assign accept      = req_valid && req_ready;
   assign searching   = (state_q == ST_SEARCH);
   assign free_vec    = ~(in_v_q | out_v_q | mask_q);
   assign cur_in_sw   = in_sw_q;
   assign cur_out_sw  = out_sw_q;
   assign pick_onehot = N_MID'(1) << pick_idx;

   assign do_block  = searching && !pick_found;
   assign cmt_en    = searching && pick_found && !pick_busy;
   assign do_resend = searching && pick_found && pick_busy && (cnt_q == LIM);
   assign do_cancel = searching && pick_found && pick_busy && (cnt_q != LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         in_v_q   <= '0;
         out_v_q  <= '0;
         mask_q   <= '0;
         in_sw_q  <= '0;
         out_sw_q <= '0;
         cnt_q    <= '0;
      end else if (accept) begin
         state_q  <= ST_SEARCH;
         in_v_q   <= req_in_vec;
         out_v_q  <= req_out_vec;
         mask_q   <= '0;
         in_sw_q  <= req_in_sw;
         out_sw_q <= req_out_sw;
         cnt_q    <= '0;
      end else if (do_cancel) begin
         mask_q <= mask_q | pick_onehot;
         cnt_q  <= cnt_q + 1'b1;
      end else if (do_block || cmt_en || do_resend) begin
         state_q <= ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_code    <= RES_NONE;
         res_mid     <= '0;
         res_in_vec  <= '0;
         res_out_vec <= '0;
      end else begin
         res_valid <= do_block || cmt_en || do_resend;
         if (cmt_en) begin
            res_code    <= RES_GRANT;
            res_mid     <= pick_idx;
            res_in_vec  <= in_v_q | pick_onehot;
            res_out_vec <= out_v_q | pick_onehot;
         end else if (do_block) begin
            res_code    <= RES_BLOCKED;
            res_mid     <= '0;
            res_in_vec  <= in_v_q;
            res_out_vec <= out_v_q;
         end else if (do_resend) begin
            res_code    <= RES_RESEND;
            res_mid     <= '0;
            res_in_vec  <= in_v_q;
            res_out_vec <= out_v_q;
         end
      end
   end

   // R2: the switch under trial is a true candidate
   a_r2_pick_is_free: assert property (@(posedge clk) disable iff (!rst_n)
      (searching && pick_found) |-> !(in_v_q[pick_idx] | out_v_q[pick_idx] | mask_q[pick_idx]));

   // R6: the cancel count never passes its limit
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM);

   // R5: a cancelled switch joins the exclusion mask
   a_r5_cancel_masks: assert property (@(posedge clk) disable iff (!rst_n)
      do_cancel |=> mask_q[$past(pick_idx)]);

   // R9: results are single-cycle pulses, delivered while idle
   a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   a_r9_idle_at_result: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> req_ready);

endmodule

// File: rtl/clos_mid_selector.sv
module clos_mid_selector
   import clos_sel_pkg::*;
#(
   parameter int N_MID        = 32,
   parameter int N_IN         = 8,
   parameter int N_OUT        = 8,
   parameter int CANCEL_LIMIT = 3,
   localparam int MIDW  = (N_MID > 1) ? $clog2(N_MID) : 1,
   localparam int INW   = (N_IN  > 1) ? $clog2(N_IN)  : 1,
   localparam int OUTW  = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [INW-1:0]   req_in_sw,
   input  logic [OUTW-1:0]  req_out_sw,
   input  logic [N_MID-1:0] req_in_vec,
   input  logic [N_MID-1:0] req_out_vec,
   input  logic             rel_valid,
   input  logic [MIDW-1:0]  rel_mid,
   input  logic [INW-1:0]   rel_in_sw,
   input  logic [OUTW-1:0]  rel_out_sw,
   output logic             res_valid,
   output logic [1:0]       res_code,
   output logic [MIDW-1:0]  res_mid,
   output logic [N_MID-1:0] res_in_vec,
   output logic [N_MID-1:0] res_out_vec
);

   logic [N_MID-1:0] free_vec;
   logic             pick_found, pick_busy, cmt_en;
   logic [MIDW-1:0]  pick_idx;
   logic [INW-1:0]   cur_in_sw;
   logic [OUTW-1:0]  cur_out_sw;

   clos_sel_ctrl #(
      .N_MID(N_MID), .N_IN(N_IN), .N_OUT(N_OUT), .CANCEL_LIMIT(CANCEL_LIMIT)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_in_sw(req_in_sw), .req_out_sw(req_out_sw),
      .req_in_vec(req_in_vec), .req_out_vec(req_out_vec),
      .free_vec(free_vec), .pick_found(pick_found), .pick_idx(pick_idx),
      .cur_in_sw(cur_in_sw), .cur_out_sw(cur_out_sw),
      .pick_busy(pick_busy), .cmt_en(cmt_en),
      .res_valid(res_valid), .res_code(res_code), .res_mid(res_mid),
      .res_in_vec(res_in_vec), .res_out_vec(res_out_vec)
   );

   clos_free_pick #(.N(N_MID)) u_pick (
      .free_vec(free_vec), .found(pick_found), .idx(pick_idx)
   );

   clos_relay_table #(.N_MID(N_MID), .N_IN(N_IN), .N_OUT(N_OUT)) u_table (
      .clk(clk), .rst_n(rst_n),
      .look_mid(pick_idx), .look_in(cur_in_sw), .look_out(cur_out_sw),
      .look_busy(pick_busy),
      .cmt_en(cmt_en), .cmt_mid(pick_idx), .cmt_in(cur_in_sw), .cmt_out(cur_out_sw),
      .rel_en(rel_valid), .rel_mid(rel_mid), .rel_in(rel_in_sw), .rel_out(rel_out_sw)
   );

   // R3: a grant reports a switch marked in both returned vectors
   a_r3_grant_vectors: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == RES_GRANT) |-> (res_in_vec[res_mid] && res_out_vec[res_mid]));

endmodule

// File: tb/sim_clos_mid_selector.sv
module sim_clos_mid_selector;

   localparam int CLK_PERIOD = 10;
   localparam int NM = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_in_sw = '0, req_out_sw = '0;
   logic [NM-1:0] req_in_vec = '0, req_out_vec = '0;
   logic          rel_valid = 1'b0;
   logic [4:0]    rel_mid = '0;
   logic [2:0]    rel_in_sw = '0, rel_out_sw = '0;
   logic          res_valid;
   logic [1:0]    res_code;
   logic [4:0]    res_mid;
   logic [NM-1:0] res_in_vec, res_out_vec;

   always #(CLK_PERIOD / 2) clk = ~clk;

   clos_mid_selector u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_in_sw(req_in_sw), .req_out_sw(req_out_sw),
      .req_in_vec(req_in_vec), .req_out_vec(req_out_vec),
      .rel_valid(rel_valid), .rel_mid(rel_mid),
      .rel_in_sw(rel_in_sw), .rel_out_sw(rel_out_sw),
      .res_valid(res_valid), .res_code(res_code), .res_mid(res_mid),
      .res_in_vec(res_in_vec), .res_out_vec(res_out_vec)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   logic [1:0]    g_code;
   logic [4:0]    g_mid;
   logic [NM-1:0] g_iv, g_ov;
   int            g_lat;

   task automatic issue(input logic [2:0] isw, input logic [2:0] osw,
                        input logic [NM-1:0] iv, input logic [NM-1:0] ov);
      @(negedge clk);
      req_in_sw = isw; req_out_sw = osw; req_in_vec = iv; req_out_vec = ov;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      g_lat = 1;
      while (!res_valid && g_lat < 40) begin
         @(negedge clk);
         g_lat++;
      end
      g_code = res_code; g_mid = res_mid; g_iv = res_in_vec; g_ov = res_out_vec;
   endtask

   task automatic release_link(input logic [4:0] m, input logic [2:0] isw, input logic [2:0] osw);
      @(negedge clk);
      rel_valid = 1'b1; rel_mid = m; rel_in_sw = isw; rel_out_sw = osw;
      @(negedge clk);
      rel_valid = 1'b0;
   endtask

   typedef struct packed {
      logic [NM-1:0] iv;
      logic [NM-1:0] ov;
      logic [2:0]    isw;
      logic [2:0]    osw;
      logic [1:0]    code;
      logic [4:0]    mid;
   } vec_t;

   // R2/R3/R7: code 1 grant, 2 blocked; bit k of a vector = middle switch k
   localparam vec_t VEC [7] = '{
      '{32'h0000_0000, 32'h0000_0000, 3'd0, 3'd0, 2'd1, 5'd0},
      '{32'h0000_0032, 32'h0000_0053, 3'd1, 3'd2, 2'd1, 5'd2},
      '{32'hFFFF_FFFF, 32'h0000_0000, 3'd2, 3'd3, 2'd2, 5'd0},
      '{32'h7FFF_FFFF, 32'h0000_0000, 3'd3, 3'd4, 2'd1, 5'd31},
      '{32'h0000_FFFF, 32'hFFFF_0000, 3'd4, 3'd5, 2'd2, 5'd0},
      '{32'h5555_5555, 32'h2222_2222, 3'd5, 3'd6, 2'd1, 5'd3},
      '{32'h0000_0000, 32'hFFFF_FFFE, 3'd7, 3'd7, 2'd1, 5'd0}
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
      chk(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table of vectors, each grant released afterwards
      foreach (VEC[i]) begin
         issue(VEC[i].isw, VEC[i].osw, VEC[i].iv, VEC[i].ov);
         chk(g_code == VEC[i].code, $sformatf("R2 R7 vec%0d code", i), g_code, VEC[i].code);
         chk(g_lat == 2, $sformatf("R3 vec%0d latency", i), g_lat, 2);
         if (VEC[i].code == 2'd1) begin
            chk(g_mid == VEC[i].mid, $sformatf("R2 vec%0d mid", i), g_mid, VEC[i].mid);
            chk(g_iv == (VEC[i].iv | (NM'(1) << VEC[i].mid)),
                $sformatf("R3 vec%0d in_vec", i), g_iv, VEC[i].iv | (NM'(1) << VEC[i].mid));
            chk(g_ov == (VEC[i].ov | (NM'(1) << VEC[i].mid)),
                $sformatf("R3 vec%0d out_vec", i), g_ov, VEC[i].ov | (NM'(1) << VEC[i].mid));
            release_link(VEC[i].mid, VEC[i].isw, VEC[i].osw);
         end
      end

      // R9: req_valid held through the search yields one result
      begin
         int pulses = 0;
         @(negedge clk);
         req_in_sw = 3'd0; req_out_sw = 3'd0; req_in_vec = '0; req_out_vec = '0;
         req_valid = 1'b1;
         @(negedge clk);
         chk(req_ready == 1'b0, "R9 not ready while searching", req_ready, 0);
         @(negedge clk);
         if (res_valid) pulses++;
         req_valid = 1'b0;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (res_valid) pulses++;
         end
         chk(pulses == 1, "R9 one result per request", pulses, 1);
      end
      // middle 0 now holds in-sw 0 and out-sw 0 (R1: switch 0 granted first)

      // R4 R5: stale vectors pick switch 0, cancelled, switch 1 granted
      issue(3'd0, 3'd1, '0, '0);
      chk(g_code == 2'd1, "R5 grant after cancel code", g_code, 1);
      chk(g_mid == 5'd1, "R4 R5 next switch after cancel", g_mid, 1);
      chk(g_lat == 3, "R5 one extra cycle per cancel", g_lat, 3);

      issue(3'd0, 3'd2, 32'h3, '0);
      chk(g_mid == 5'd2 && g_code == 2'd1, "R2 grant mid 2", g_mid, 2);
      issue(3'd0, 3'd3, 32'h7, '0);
      chk(g_mid == 5'd3 && g_code == 2'd1, "R2 grant mid 3", g_mid, 3);
      issue(3'd0, 3'd4, 32'hF, '0);
      chk(g_mid == 5'd4 && g_code == 2'd1, "R2 grant mid 4", g_mid, 4);

      // R6: four cancels on switches 0..3 -> resend
      issue(3'd0, 3'd5, '0, '0);
      chk(g_code == 2'd3, "R6 resend code", g_code, 3);
      chk(g_lat == 5, "R6 resend latency", g_lat, 5);

      // R10: only switches 0 and 1 offered, both conflict -> blocked
      issue(3'd0, 3'd6, 32'hFFFF_FFFC, '0);
      chk(g_code == 2'd2, "R10 blocked after cancels", g_code, 2);
      chk(g_lat == 4, "R10 blocked latency", g_lat, 4);

      // R8: release all, then switch 0 is granted again at once
      release_link(5'd0, 3'd0, 3'd0);
      release_link(5'd1, 3'd0, 3'd1);
      release_link(5'd2, 3'd0, 3'd2);
      release_link(5'd3, 3'd0, 3'd3);
      release_link(5'd4, 3'd0, 3'd4);
      issue(3'd0, 3'd5, '0, '0);
      chk(g_code == 2'd1 && g_mid == 5'd0, "R8 R6 freed switch granted", g_mid, 0);
      chk(g_lat == 2, "R8 no cancel after release", g_lat, 2);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule